// File: doc/BRIEF.md
# Ternary Header Match Array

This block compares a 72-bit packet header key against a bank of stored ternary entries and reports every entry that matches. The key holds the protocol byte in bits 7:0, the destination address in bits 39:8 and the source address in bits 71:40. Each entry stores a value, a care mask and a valid flag. Only the key bits whose mask bit is 1 take part in the comparison. A left-aligned mask therefore gives an address prefix, and an all-zero protocol mask makes the protocol a wildcard.

The result is a raw vector with one bit per entry, and any number of its bits may be set. No priority encoding is applied. Port fields are not part of the key, so port ranges never multiply the number of entries; another engine combines this vector with its own port results. A write port loads, replaces or removes one entry per cycle while lookups go on.

Top module: `hdr_tmatch`

## Requirements
- R1: After reset every entry is invalid, `res_vld` is 0 and `res_vec` is all zeros. A lookup made before any write returns all zeros.
- R2: A lookup presented with `lk_en` high at one rising edge gives `res_vld` high and a new `res_vec` after that edge. At an edge where `lk_en` is low, `res_vld` goes low and `res_vec` keeps its previous value.
- R3: Bit i of `res_vec` is 1 exactly when entry i is valid and the key agrees with the stored value on every bit where the entry's mask is 1.
- R4: Several entries can match one key. Every matching entry sets its own bit, and none hides another.
- R5: Key bits where the mask is 0 are ignored. A valid entry with an all-zero mask matches every key.
- R6: An invalid entry never matches. Writing an entry with `wr_valid` = 0 removes it from all later lookups.
- R7: A write with `wr_en` high takes effect at its rising edge. A lookup sampled at that same edge sees the old contents, and a lookup at the next edge sees the new contents.
- R8: A write whose `wr_idx` is ENTRIES or greater changes no entry. Index ENTRIES-1 (32 by default) is a usable entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | IDX_W (6) | Entry to write |
| wr_valid | input | 1 | Valid flag written to the entry |
| wr_value | input | KEY_W (72) | Stored compare value |
| wr_mask | input | KEY_W (72) | Care mask, 1 = bit compared |
| lk_en | input | 1 | Lookup request |
| lk_key | input | KEY_W (72) | Key: {source IP, destination IP, protocol} |
| res_vld | output | 1 | Result present this cycle |
| res_vec | output | ENTRIES (33) | Per-entry match bits |

## Verification
The bench loads overlapping prefix, exact-protocol and wildcard entries, then sends keys that hit none, one or several of them. A design with a priority encoder, or one that compared the masked bits, would produce wrong vectors. It writes an entry at the same edge as a lookup of its key, to catch a forwarding path that leaks new contents into the old lookup. It also removes an entry through `wr_valid` = 0, writes to an index past the last entry, which must not alias onto a real entry, and checks that `res_vec` holds when no lookup is made.

// File: rtl/hdr_tmatch.sv
module hdr_tmatch #(
  parameter int KEY_W   = 72,
  parameter int ENTRIES = 33,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_valid,
  input  logic [KEY_W-1:0]   wr_value,
  input  logic [KEY_W-1:0]   wr_mask,
  input  logic               lk_en,
  input  logic [KEY_W-1:0]   lk_key,
  output logic               res_vld,
  output logic [ENTRIES-1:0] res_vec
);

  logic [ENTRIES-1:0][KEY_W-1:0] val_q;
  logic [ENTRIES-1:0][KEY_W-1:0] msk_q;
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign hit[i] = valid_q[i] && (((lk_key ^ val_q[i]) & msk_q[i]) == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        val_q[i]   <= '0;
        msk_q[i]   <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        valid_q[i] <= wr_valid;
        val_q[i]   <= wr_value;
        msk_q[i]   <= wr_mask;
      end
    end

    p_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en && !valid_q[i]) |=> !res_vec[i]);

    p_wild_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en && valid_q[i] && msk_q[i] == '0) |=> res_vec[i]);

    p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=> valid_q[i] == $past(wr_valid));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_vec <= '0;
    end else begin
      res_vld <= lk_en;
      if (lk_en) res_vec <= hit;
    end
  end

  p_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_vld == $past(lk_en));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(lk_en)) |-> $stable(res_vec));

  p_oob_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= ENTRIES) |=> $stable(valid_q));

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!res_vld && res_vec == '0 && valid_q == '0));

endmodule

// File: tb/test_hdr_tmatch.sv
module test_hdr_tmatch;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_W = 72;
  localparam int ENTRIES = 33;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NVEC = 5;

  // each row: {key, expected bits for entries 4..0}; higher entries expected 0
  localparam logic [KEY_W+4:0] VECS [NVEC] = '{
    {32'hC0A80101, 32'h0A000001, 8'd6,  5'b01001},
    {32'hC0A90101, 32'hC0A83202, 8'd6,  5'b01010},
    {32'hC0A80005, 32'hC0A83202, 8'd17, 5'b01110},
    {32'hC0A8FFFF, 32'hC0A83202, 8'd6,  5'b01011},
    {32'h00000000, 32'hC0A83203, 8'd1,  5'b01000}
  };
  localparam logic [KEY_W-1:0] K5 = {32'h00000000, 32'hC0A83203, 8'd1};
  localparam logic [KEY_W-1:0] ONES = '1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, lk_en = 0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [KEY_W-1:0] wr_value = '0, wr_mask = '0, lk_key = '0;
  logic res_vld;
  logic [ENTRIES-1:0] res_vec;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_tmatch #(.KEY_W(KEY_W), .ENTRIES(ENTRIES)) i_hdr_tmatch (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_valid, .wr_value, .wr_mask,
    .lk_en, .lk_key, .res_vld, .res_vec);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic v, logic [KEY_W-1:0] val, logic [KEY_W-1:0] msk);
    @(negedge clk);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_valid = v; wr_value = val; wr_mask = msk;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(logic [KEY_W-1:0] k);
    @(negedge clk);
    lk_en = 1; lk_key = k;
    @(negedge clk);
    lk_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", 64'(res_vld), 0);
    chk("R1 vec in reset", 64'(res_vec), 0);
    rst_n = 1;
    look(VECS[0][KEY_W+4:5]);
    chk("R1 empty lookup", 64'(res_vec), 0);
    chk("R2 vld after lookup", 64'(res_vld), 1);

    wr(0, 1, {32'hC0A80000, 32'h0, 8'd6}, {32'hFFFF0000, 32'h0, 8'hFF});
    wr(1, 1, {32'h0, 32'hC0A83202, 8'd0}, {32'h0, 32'hFFFFFFFF, 8'h00});
    wr(2, 1, {32'h0, 32'h0, 8'd17}, {32'h0, 32'h0, 8'hFF});
    wr(3, 1, '0, '0);
    wr(4, 1, K5, ONES);
    wr(4, 0, K5, ONES);

    for (int n = 0; n < NVEC; n++) begin
      look(VECS[n][KEY_W+4:5]);
      chk($sformatf("R3 R4 R5 R6 vector %0d", n), 64'(res_vec), 64'(VECS[n][4:0]));
    end

    @(negedge clk); lk_key = '0;
    @(negedge clk);
    chk("R2 vld low when idle", 64'(res_vld), 0);
    chk("R2 vec held when idle", 64'(res_vec), 64'(5'b01000));

    @(negedge clk);
    lk_en = 1; lk_key = K5;
    wr_en = 1; wr_idx = IDX_W'(5); wr_valid = 1; wr_value = K5; wr_mask = ONES;
    @(negedge clk);
    wr_en = 0;
    chk("R7 same-edge sees old", 64'(res_vec), 64'(5'b01000));
    @(negedge clk);
    lk_en = 0;
    chk("R7 next edge sees new", 64'(res_vec), 64'(6'b101000));

    wr(40, 1, '0, '0);
    look(VECS[0][KEY_W+4:5]);
    chk("R8 out-of-range write ignored", 64'(res_vec), 64'(5'b01001));
    wr(32, 1, '0, '0);
    look(K5);
    chk("R8 last entry usable", 64'(res_vec), (64'd1 << 32) | 64'(6'b101000));
    wr(3, 0, '0, '0);
    look(K5);
    chk("R6 removed wildcard", 64'(res_vec), (64'd1 << 32) | 64'(6'b100000));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule